// File: doc/BRIEF.md
# RISC Decode and Execute Unit

A purely combinational unit that takes one 32-bit instruction word of a small load/store RISC subset, together with the values of its two source registers. It splits the word into its fields, finds the operation, and produces either an arithmetic, logic, shift or immediate result, or the effective address of a data memory access.

Its outputs give the register writeback index, a write enable, the writeback value, and a memory request: read, write, access size, load signedness, address and store data. Aligning and extending load data, the register file, the program counter and all control flow sit in neighbouring blocks.

For loads, `wb_data_o` is zero; the load path substitutes the extended memory data. Any encoding outside the supported set is flagged as illegal, and every side effect is suppressed.

Top module: `dx_unit`

## Requirements
- R1: With op field instr[31:26] = 0, func instr[5:0] = 0x21 gives rs+rt and 0x23 gives rs-rt, both wrapping modulo 2^32 with no overflow indication; rs is instr[25:21], rt is instr[20:16], rd is instr[15:11].
- R2: With op = 0, func 0x25 gives rs|rt, 0x26 gives rs^rt and 0x27 gives ~(rs|rt).
- R3: With op = 0, func 0x00 shifts rt left, 0x02 shifts rt right with zero fill and 0x03 shifts rt right with sign fill, each by shamt = instr[10:6]; the rs value has no effect.
- R4: Op 0x09 adds rs to the sign-extended imm = instr[15:0], op 0x0c ANDs rs with the zero-extended imm, and op 0x0d ORs rs with the zero-extended imm.
- R5: Op 0x0f gives imm in bits [31:16] of the result and zero in bits [15:0].
- R6: Every legal non-store instruction asserts `reg_we_o`; R-type instructions write to index rd, and immediate and load instructions write to index rt. When `reg_we_o` is 0, `rd_idx_o` is 0.
- R7: Load ops 0x20, 0x24, 0x21, 0x25 and 0x23 assert `mem_rd_o` with `mem_size_o` 0, 0, 1, 1 and 2 (0 byte, 1 half, 2 word). `mem_signed_o` is 1 only for 0x20 and 0x21. `mem_addr_o` is rs plus the sign-extended imm, and `wb_data_o` is 0.
- R8: Store ops 0x28, 0x29 and 0x2b assert `mem_wr_o` with sizes 0, 1 and 2. They present rt on `mem_wdata_o` and the rs+sext(imm) address, and deassert `reg_we_o`.
- R9: Any other op, or op 0 with any other func, asserts `illegal_o` and drives every other output to 0.
- R10: Non-memory instructions drive `mem_rd_o`, `mem_wr_o`, `mem_size_o`, `mem_signed_o`, `mem_addr_o` and `mem_wdata_o` to 0. A store drives `wb_data_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | XLEN | Value of source register rs |
| rt_val_i | input | XLEN | Value of source register rt |
| rd_idx_o | output | 5 | Writeback register index |
| reg_we_o | output | 1 | Register write enable |
| wb_data_o | output | XLEN | Writeback value (0 for loads) |
| mem_rd_o | output | 1 | Data memory read request |
| mem_wr_o | output | 1 | Data memory write request |
| mem_size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_signed_o | output | 1 | Load result is sign-extended |
| mem_addr_o | output | XLEN | Effective byte address |
| mem_wdata_o | output | XLEN | Store data |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The assertions check the following relations whenever inputs change:
- A flagged illegal word has no side effect.
- Reads and writes never coincide.
- A store never writes back and always carries rt with the rs-plus-offset address.
- Signedness appears only on sub-word reads.
- The upper-immediate result has a clear low half.

Only the directed scenarios can show the actual arithmetic, logic and shift values. The same holds for the wrap at 2^32, the per-opcode choice between sign and zero extension, the mapping of each opcode to its size code, and the choice of destination field.

// File: rtl/dx_pkg.sv
package dx_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned IMM_W  = 16;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_ANDI  = 6'h0c;
  localparam logic [5:0] OPC_ORI   = 6'h0d;
  localparam logic [5:0] OPC_LUI   = 6'h0f;
  localparam logic [5:0] OPC_LB    = 6'h20;
  localparam logic [5:0] OPC_LH    = 6'h21;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_LBU   = 6'h24;
  localparam logic [5:0] OPC_LHU   = 6'h25;
  localparam logic [5:0] OPC_SB    = 6'h28;
  localparam logic [5:0] OPC_SH    = 6'h29;
  localparam logic [5:0] OPC_SW    = 6'h2b;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} mem_size_e;

  typedef enum logic [3:0] {
    FN_ADD_E, FN_SUB_E, FN_OR_E, FN_XOR_E, FN_NOR_E, FN_AND_E,
    FN_SLL_E, FN_SRL_E, FN_SRA_E, FN_LUI_E
  } alu_fn_e;

  typedef enum logic [1:0] {OPB_RT, OPB_SEXT, OPB_ZEXT} opb_sel_e;

  typedef struct packed {
    alu_fn_e   fn;
    opb_sel_e  opb;
    logic      dst_rd;
    logic      reg_we;
    logic      wb_alu;
    logic      mem_rd;
    logic      mem_wr;
    mem_size_e size;
    logic      mem_signed;
    logic      illegal;
  } ctrl_t;
endpackage

// File: rtl/dx_decode.sv
module dx_decode
  import dx_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  output ctrl_t             ctrl_o
);
  logic [5:0] opc, fnc;
  assign opc = instr_i[31:26];
  assign fnc = instr_i[5:0];

  always_comb begin
    ctrl_o = '{fn: FN_ADD_E, opb: OPB_RT, dst_rd: 1'b0, reg_we: 1'b0, wb_alu: 1'b0,
               mem_rd: 1'b0, mem_wr: 1'b0, size: SZ_BYTE, mem_signed: 1'b0,
               illegal: 1'b0};
    unique case (opc)
      OPC_REG: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.wb_alu = 1'b1;
        unique case (fnc)
          FN_ADDU: ctrl_o.fn = FN_ADD_E;
          FN_SUBU: ctrl_o.fn = FN_SUB_E;
          FN_OR:   ctrl_o.fn = FN_OR_E;
          FN_XOR:  ctrl_o.fn = FN_XOR_E;
          FN_NOR:  ctrl_o.fn = FN_NOR_E;
          FN_SLL:  ctrl_o.fn = FN_SLL_E;
          FN_SRL:  ctrl_o.fn = FN_SRL_E;
          FN_SRA:  ctrl_o.fn = FN_SRA_E;
          default: begin
            ctrl_o.illegal = 1'b1;
            ctrl_o.dst_rd  = 1'b0;
            ctrl_o.reg_we  = 1'b0;
            ctrl_o.wb_alu  = 1'b0;
          end
        endcase
      end
      OPC_ADDIU, OPC_ANDI, OPC_ORI, OPC_LUI: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.wb_alu = 1'b1;
        unique case (opc)
          OPC_ADDIU: begin ctrl_o.fn = FN_ADD_E; ctrl_o.opb = OPB_SEXT; end
          OPC_ANDI:  begin ctrl_o.fn = FN_AND_E; ctrl_o.opb = OPB_ZEXT; end
          OPC_ORI:   begin ctrl_o.fn = FN_OR_E;  ctrl_o.opb = OPB_ZEXT; end
          default:   begin ctrl_o.fn = FN_LUI_E; ctrl_o.opb = OPB_ZEXT; end
        endcase
      end
      OPC_LB, OPC_LBU, OPC_LH, OPC_LHU, OPC_LW: begin
        ctrl_o.reg_we     = 1'b1;
        ctrl_o.mem_rd     = 1'b1;
        ctrl_o.mem_signed = (opc == OPC_LB) || (opc == OPC_LH);
        ctrl_o.size       = (opc == OPC_LW) ? SZ_WORD :
                            ((opc == OPC_LH) || (opc == OPC_LHU)) ? SZ_HALF : SZ_BYTE;
      end
      OPC_SB, OPC_SH, OPC_SW: begin
        ctrl_o.mem_wr = 1'b1;
        ctrl_o.size   = (opc == OPC_SW) ? SZ_WORD : (opc == OPC_SH) ? SZ_HALF : SZ_BYTE;
      end
      default: ctrl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/dx_alu.sv
module dx_alu
  import dx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_fn_e           fn_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [4:0]        shamt_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [XLEN-1:0]   res_o
);
  always_comb begin
    unique case (fn_i)
      FN_ADD_E: res_o = a_i + b_i;
      FN_SUB_E: res_o = a_i - b_i;
      FN_OR_E:  res_o = a_i | b_i;
      FN_XOR_E: res_o = a_i ^ b_i;
      FN_NOR_E: res_o = ~(a_i | b_i);
      FN_AND_E: res_o = a_i & b_i;
      FN_SLL_E: res_o = b_i << shamt_i;
      FN_SRL_E: res_o = b_i >> shamt_i;
      FN_SRA_E: res_o = $unsigned($signed(b_i) >>> shamt_i);
      FN_LUI_E: res_o = XLEN'(imm_i) << IMM_W;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/dx_agu.sv
module dx_agu
  import dx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] ofs_i,
  output logic [XLEN-1:0]  addr_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;
  assign addr_o = base_i + {{EXT_W{ofs_i[IMM_W-1]}}, ofs_i};
endmodule

// File: rtl/dx_unit.sv
module dx_unit
  import dx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSN_W-1:0] instr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              reg_we_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [1:0]        mem_size_o,
  output logic              mem_signed_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic              illegal_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  ctrl_t              ctrl;
  logic [IMM_W-1:0]   imm;
  logic [IDX_W-1:0]   f_rt, f_rd;
  logic [XLEN-1:0]    opb, alu_res, agu_addr;
  logic               mem_any;

  assign imm  = instr_i[15:0];
  assign f_rt = instr_i[20:16];
  assign f_rd = instr_i[15:11];

  dx_decode u_dec (.instr_i(instr_i), .ctrl_o(ctrl));

  always_comb begin
    unique case (ctrl.opb)
      OPB_SEXT: opb = {{EXT_W{imm[IMM_W-1]}}, imm};
      OPB_ZEXT: opb = {{EXT_W{1'b0}}, imm};
      default:  opb = rt_val_i;
    endcase
  end

  dx_alu #(.XLEN(XLEN)) u_alu (
    .fn_i(ctrl.fn), .a_i(rs_val_i), .b_i(opb),
    .shamt_i(instr_i[10:6]), .imm_i(imm), .res_o(alu_res)
  );

  dx_agu #(.XLEN(XLEN)) u_agu (.base_i(rs_val_i), .ofs_i(imm), .addr_o(agu_addr));

  assign mem_any      = ctrl.mem_rd | ctrl.mem_wr;
  assign reg_we_o     = ctrl.reg_we;
  assign rd_idx_o     = ctrl.reg_we ? (ctrl.dst_rd ? f_rd : f_rt) : '0;
  assign wb_data_o    = ctrl.wb_alu ? alu_res : '0;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign mem_size_o   = ctrl.size;
  assign mem_signed_o = ctrl.mem_signed;
  assign mem_addr_o   = mem_any ? agu_addr : '0;
  assign mem_wdata_o  = ctrl.mem_wr ? rt_val_i : '0;
  assign illegal_o    = ctrl.illegal;
endmodule

// File: rtl/dx_unit_chk.sv
module dx_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic [4:0]      rd_idx_o,
  input logic            reg_we_o,
  input logic [XLEN-1:0] wb_data_o,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic [1:0]      mem_size_o,
  input logic            mem_signed_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o,
  input logic            illegal_o
);
  logic [XLEN-1:0] exp_addr;
  assign exp_addr = rs_val_i + XLEN'($signed(instr_i[15:0]));

  always_comb begin
    a_r9_no_side_effect: assert (!illegal_o || (!reg_we_o && !mem_rd_o && !mem_wr_o
                                 && wb_data_o == '0 && mem_addr_o == '0))
      else $error("illegal word has side effect");
    a_r10_rd_wr_exclusive: assert (!(mem_rd_o && mem_wr_o))
      else $error("read and write together");
    a_r8_store_no_wb: assert (!mem_wr_o || (!reg_we_o && mem_wdata_o == rt_val_i
                              && mem_addr_o == exp_addr))
      else $error("store request malformed");
    a_r7_signed_subword: assert (!mem_signed_o || (mem_rd_o && mem_size_o != 2'd2))
      else $error("signedness outside sub-word load");
    a_r5_lui_low_clear: assert (!(instr_i[31:26] == 6'h0f) || wb_data_o[15:0] == 16'h0)
      else $error("upper immediate low half not clear");
    a_r6_idx_idle: assert (reg_we_o || rd_idx_o == 5'd0)
      else $error("index driven without write");
  end
endmodule

bind dx_unit dx_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_dx_unit.sv
module sim_dx_unit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr, rs_v, rt_v, wb, addr, wdata;
  logic [4:0]  rd_idx;
  logic [1:0]  msize;
  logic        we, mrd, mwr, msgn, ill;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  dx_unit u0 (
    .instr_i(instr), .rs_val_i(rs_v), .rt_val_i(rt_v), .rd_idx_o(rd_idx),
    .reg_we_o(we), .wb_data_o(wb), .mem_rd_o(mrd), .mem_wr_o(mwr),
    .mem_size_o(msize), .mem_signed_o(msgn), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .illegal_o(ill)
  );

  function automatic logic [31:0] rty(input logic [5:0] f, input logic [4:0] s, t, d,
                                      input logic [4:0] sh);
    return {6'h00, s, t, d, sh, f};
  endfunction
  function automatic logic [31:0] ity(input logic [5:0] o, input logic [4:0] s, t,
                                      input logic [15:0] im);
    return {o, s, t, im};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, a, b);
    @(negedge clk);
    instr = i; rs_v = a; rt_v = b;
    @(posedge clk);
    #1;
  endtask

  task automatic no_mem(input string tag);
    chk({tag, " R10 mem idle"}, {30'd0, mrd, mwr}, 32'd0);
    chk({tag, " R10 mem fields"}, {29'd0, msize, msgn}, 32'd0);
    chk({tag, " R10 addr"}, addr, 32'd0);
    chk({tag, " R10 wdata"}, wdata, 32'd0);
  endtask

  task automatic t_idle;
    apply(32'h0, 32'h0, 32'h0);
    chk("R6 idle we", {31'd0, we}, 32'd1);
    chk("R6 idle idx", {27'd0, rd_idx}, 32'd0);
    chk("R9 idle legal", {31'd0, ill}, 32'd0);
    chk("R3 idle wb", wb, 32'd0);
  endtask

  task automatic t_addsub;
    apply(rty(6'h21, 5'd1, 5'd2, 5'd7, 5'd0), 32'hFFFF_FFFF, 32'h2);
    chk("R1 addu wrap", wb, 32'h1);
    chk("R6 rtype dest", {27'd0, rd_idx}, 32'd7);
    no_mem("addu");
    apply(rty(6'h23, 5'd1, 5'd2, 5'd9, 5'd0), 32'h0, 32'h1);
    chk("R1 subu wrap", wb, 32'hFFFF_FFFF);
    chk("R9 subu no flag", {31'd0, ill}, 32'd0);
  endtask

  task automatic t_logic;
    logic [31:0] a = 32'hF0F0_1234, b = 32'h0FF0_8001;
    apply(rty(6'h25, 5'd3, 5'd4, 5'd5, 5'd0), a, b);
    chk("R2 or", wb, a | b);
    apply(rty(6'h26, 5'd3, 5'd4, 5'd5, 5'd0), a, b);
    chk("R2 xor", wb, a ^ b);
    apply(rty(6'h27, 5'd3, 5'd4, 5'd5, 5'd0), a, b);
    chk("R2 nor", wb, ~(a | b));
  endtask

  task automatic t_shift;
    apply(rty(6'h00, 5'd3, 5'd4, 5'd8, 5'd6), 32'hDEAD_BEEF, 32'h0000_0003);
    chk("R3 sll", wb, 32'h0000_00C0);
    apply(rty(6'h02, 5'd3, 5'd4, 5'd8, 5'd4), 32'h1234_5678, 32'h8000_0000);
    chk("R3 srl zero fill", wb, 32'h0800_0000);
    apply(rty(6'h03, 5'd3, 5'd4, 5'd8, 5'd4), 32'h0, 32'h8000_0000);
    chk("R3 sra sign fill", wb, 32'hF800_0000);
    apply(rty(6'h03, 5'd3, 5'd4, 5'd8, 5'd31), 32'h0, 32'h7FFF_FFFF);
    chk("R3 sra positive", wb, 32'h0);
    apply(rty(6'h02, 5'd3, 5'd4, 5'd8, 5'd4), 32'hFFFF_FFFF, 32'h8000_0000);
    chk("R3 rs ignored", wb, 32'h0800_0000);
  endtask

  task automatic t_imm;
    apply(ity(6'h09, 5'd5, 5'd6, 16'hFFFF), 32'h0000_0010, 32'hAAAA_AAAA);
    chk("R4 addiu sext", wb, 32'h0000_000F);
    chk("R6 imm dest rt", {27'd0, rd_idx}, 32'd6);
    no_mem("addiu");
    apply(ity(6'h0c, 5'd5, 5'd6, 16'h8001), 32'hFFFF_FFFF, 32'h0);
    chk("R4 andi zext", wb, 32'h0000_8001);
    apply(ity(6'h0d, 5'd5, 5'd6, 16'h8000), 32'h0000_0001, 32'h0);
    chk("R4 ori zext", wb, 32'h0000_8001);
  endtask

  task automatic t_lui;
    apply(ity(6'h0f, 5'd9, 5'd10, 16'hDEAD), 32'hFFFF_FFFF, 32'h0);
    chk("R5 lui", wb, 32'hDEAD_0000);
    chk("R6 lui dest", {27'd0, rd_idx}, 32'd10);
    apply(ity(6'h0d, 5'd10, 5'd10, 16'hBEEF), 32'hDEAD_0000, 32'h0);
    chk("R5 lui then ori", wb, 32'hDEAD_BEEF);
  endtask

  task automatic t_load;
    logic [5:0] ops [5] = '{6'h20, 6'h24, 6'h21, 6'h25, 6'h23};
    logic [1:0] szs [5] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2};
    logic       sgn [5] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    for (int k = 0; k < 5; k++) begin
      apply(ity(ops[k], 5'd2, 5'd12, 16'hFFFC), 32'h0000_1000, 32'h5555_5555);
      chk("R7 load rd", {31'd0, mrd}, 32'd1);
      chk("R7 load size", {30'd0, msize}, {30'd0, szs[k]});
      chk("R7 load signed", {31'd0, msgn}, {31'd0, sgn[k]});
      chk("R7 load addr", addr, 32'h0000_0FFC);
      chk("R7 load wb zero", wb, 32'h0);
      chk("R6 load dest", {26'd0, we, rd_idx}, {26'd0, 1'b1, 5'd12});
    end
  endtask

  task automatic t_store;
    logic [5:0] ops [3] = '{6'h28, 6'h29, 6'h2b};
    for (int k = 0; k < 3; k++) begin
      apply(ity(ops[k], 5'd5, 5'd1, 16'h0004), 32'hFFFF_FFFE, 32'hCAFE_F00D);
      chk("R8 store wr", {30'd0, mrd, mwr}, 32'd1);
      chk("R8 store size", {30'd0, msize}, k);
      chk("R8 store addr", addr, 32'h0000_0002);
      chk("R8 store data", wdata, 32'hCAFE_F00D);
      chk("R8 store no wb", {31'd0, we}, 32'd0);
      chk("R10 store wb zero", wb, 32'd0);
    end
  endtask

  task automatic t_illegal;
    logic [31:0] bad [3] = '{rty(6'h20, 5'd1, 5'd2, 5'd3, 5'd0),
                             ity(6'h3f, 5'd1, 5'd2, 16'h1234),
                             ity(6'h22, 5'd1, 5'd2, 16'h0008)};
    for (int k = 0; k < 3; k++) begin
      apply(bad[k], 32'h1111_1111, 32'h2222_2222);
      chk("R9 flag", {31'd0, ill}, 32'd1);
      chk("R9 quiet ctl", {27'd0, we, mrd, mwr, msgn, 1'b0}, 32'd0);
      chk("R9 quiet data", wb | addr | wdata | {27'd0, rd_idx} | {30'd0, msize}, 32'd0);
    end
  endtask

  initial begin
    instr = '0; rs_v = '0; rt_v = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_addsub();
    t_logic();
    t_shift();
    t_imm();
    t_lui();
    t_load();
    t_store();
    t_illegal();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule